// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Image Loader

This block reads the full contents of a small three-wire serial EEPROM into an on-chip word array. On a start pulse it opens a first read with an address made of zeros only, one bit at a time, and watches the device's data-out line. The device pulls data-out low right after it has received its last address bit, so the number of bits sent until that point is the device's address width. The block then reads every word of the device in order, stores each one, and keeps a 16-bit wraparound sum of the stored words.

When the image is complete, a one-cycle done pulse is raised together with a checksum flag and the discovered width. Software or a boot sequencer then fetches any stored word through a synchronous read port. The serial clock half-period is a parameter in system clocks and is never shorter than one microsecond's worth of clocks. Words 0 to 2 of the image usually carry a 6-byte station address, low byte first in each word. The block stores these words like all the others.

Top module: `mw_eeprom_loader`

## Requirements
- R1: After reset, `ee_cs`, `ee_sk`, `ee_di`, `busy` and `done` are all low.
- R2: Each word read raises `ee_cs` first. It then sends the command bits 1, 1, 0 in that order on `ee_di`, each one set up while `ee_sk` is low and taken by the device on the rising edge. `ee_cs` is high only while the block is busy.
- R3: Every high and low level of `ee_sk` lasts exactly `max(HALF_CYCLES, CLK_MHZ)` clock cycles, where `CLK_MHZ` clocks equal one microsecond.
- R4: The sizing read sends address bits of value 0, most significant first, for at most `MAX_AW` bits. It stops at the first bit after which `ee_do` is sampled low. The width reported on `addr_width` is `MAX_AW` minus the index of that bit, which equals the number of bits sent.
- R5: If `ee_do` never reads low during the sizing read, `size_err` is set and `addr_width` is `MAX_AW`.
- R6: After the address, 16 data bits are sampled from `ee_do` while `ee_sk` is high, most significant first. The word read from address `a` is returned on `rd_data` one cycle after `rd_addr` = `a` is presented.
- R7: At the end of every word read, `ee_cs`, `ee_sk` and `ee_di` all go low. A run makes exactly 1 + 2^width separate chip-select windows: one for sizing and one per word.
- R8: `csum_ok` is 1 exactly when the 16-bit wraparound sum of all 2^width stored words equals `CSUM_TARGET` (default 0xBABA).
- R9: `busy` rises the cycle after `start` is accepted. `done` is a one-cycle pulse, and it coincides with `busy` falling and with valid `csum_ok`, `size_err` and `addr_width`.
- R10: A `start` pulse while `busy` is high has no effect. The run completes with one `done` and unchanged results.
- R11: Normal reads send the word index as `addr_width` bits, most significant first, and go through indices 0 to 2^width − 1 in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Pulse that begins sizing and a full image read |
| busy | output | 1 | High while a run is in progress |
| done | output | 1 | One-cycle pulse when the image and checksum are ready |
| csum_ok | output | 1 | Word sum matched the target |
| size_err | output | 1 | No dummy zero was seen during sizing |
| addr_width | output | $clog2(MAX_AW+1) | Discovered address width in bits |
| rd_addr | input | MAX_AW | Word index for the read port |
| rd_data | output | 16 | Stored word, one cycle after rd_addr |
| ee_cs | output | 1 | EEPROM chip select |
| ee_sk | output | 1 | EEPROM serial clock |
| ee_di | output | 1 | Serial data to the EEPROM |
| ee_do | input | 1 | Serial data from the EEPROM |

## Verification
`busy` is due one clock after the cycle that takes `start`. The run's flags are registered on the same edge as `done`, so the bench samples them on the falling edge where it first sees `done`. `rd_data` has one register stage, so each word is compared one full cycle after its index is applied. The serial timing is measured in whole clock cycles by a bench monitor of the `ee_sk` level. A behavioural EEPROM model answers on each rising `ee_sk` and checks the command bits and chip-select windows as they occur.

// File: rtl/mwr_pkg.sv
package mwr_pkg;
  localparam int unsigned WORD_W = 16;
  // command pattern sent MSB first: start bit, then read opcode
  localparam logic [2:0] READ_SEQ = 3'b110;

  typedef enum logic [1:0] {SEG_CMD, SEG_ADR, SEG_DAT} seg_e;
  typedef enum logic [2:0] {SR_IDLE, SR_CSUP, SR_LO, SR_HI, SR_END} ser_st_e;
  typedef enum logic [1:0] {TS_IDLE, TS_SIZE, TS_READ, TS_FIN} top_st_e;

  // width discovered when the dummy zero shows at remaining-bit index idx
  function automatic int unsigned width_at(int unsigned max_aw, int unsigned idx);
    return max_aw - idx;
  endfunction

  // highest word index for a given width
  function automatic int unsigned last_word(int unsigned aw);
    return (1 << aw) - 1;
  endfunction

  // 16-bit wraparound accumulation
  function automatic logic [WORD_W-1:0] sum_step(logic [WORD_W-1:0] acc,
                                                 logic [WORD_W-1:0] w);
    return acc + w;
  endfunction

  // half period never below the one-microsecond floor
  function automatic int unsigned half_floor(int unsigned req, int unsigned floor_cyc);
    return (req < floor_cyc) ? floor_cyc : req;
  endfunction
endpackage

// File: rtl/mwr_tick.sv
module mwr_tick #(
  parameter int unsigned HALF = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic tick
);
  localparam int unsigned CW = (HALF > 1) ? $clog2(HALF) : 1;

  logic [CW-1:0] cnt;

  assign tick = en && (cnt == CW'(HALF - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt <= '0;
    else if (!en || tick)  cnt <= '0;
    else                   cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/mwr_serial.sv
module mwr_serial
  import mwr_pkg::*;
#(
  parameter int unsigned MAX_AW = 8,
  parameter int unsigned HALF   = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         tick,
  input  logic                         go,
  input  logic                         sizing,
  input  logic [$clog2(MAX_AW+1)-1:0]  aw,
  input  logic [MAX_AW-1:0]            addr,
  input  logic                         ee_do,
  output logic                         ee_cs,
  output logic                         ee_sk,
  output logic                         ee_di,
  output logic                         ready,
  output logic                         active,
  output logic                         word_valid,
  output logic [WORD_W-1:0]            word,
  output logic [$clog2(MAX_AW+1)-1:0]  found_aw,
  output logic                         no_dummy
);
  localparam int unsigned AW_W  = $clog2(MAX_AW + 1);
  localparam int unsigned CNT_W = $clog2(WORD_W);
  localparam int unsigned AI    = (MAX_AW > 1) ? $clog2(MAX_AW) : 1;
  localparam int unsigned HW    = $clog2(HALF + 1);

  ser_st_e           st;
  seg_e              seg;
  logic [CNT_W-1:0]  cnt;
  logic [AW_W-1:0]   aw_q;
  logic [MAX_AW-1:0] addr_q;
  logic              size_q;
  logic              bit_val;

  assign ready  = (st == SR_IDLE);
  assign active = (st != SR_IDLE);
  assign ee_cs  = (st == SR_CSUP) || (st == SR_LO) || (st == SR_HI);
  assign ee_sk  = (st == SR_HI);

  always_comb begin
    case (seg)
      SEG_CMD: bit_val = READ_SEQ[cnt[1:0]];
      SEG_ADR: bit_val = addr_q[cnt[AI-1:0]];
      default: bit_val = 1'b0;
    endcase
  end
  assign ee_di = ((st == SR_LO) || (st == SR_HI)) && bit_val;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= SR_IDLE;
      seg        <= SEG_CMD;
      cnt        <= '0;
      aw_q       <= '0;
      addr_q     <= '0;
      size_q     <= 1'b0;
      word       <= '0;
      word_valid <= 1'b0;
      found_aw   <= '0;
      no_dummy   <= 1'b0;
    end else begin
      word_valid <= 1'b0;
      case (st)
        SR_IDLE: if (go) begin
          st       <= SR_CSUP;
          size_q   <= sizing;
          addr_q   <= sizing ? '0 : addr;
          aw_q     <= sizing ? AW_W'(MAX_AW) : aw;
          no_dummy <= 1'b0;
        end
        SR_CSUP: if (tick) begin
          st  <= SR_LO;
          seg <= SEG_CMD;
          cnt <= CNT_W'(2);
        end
        SR_LO: if (tick) st <= SR_HI;
        SR_HI: if (tick) begin
          st <= SR_LO;
          case (seg)
            SEG_CMD: begin
              if (cnt == '0) begin
                seg <= SEG_ADR;
                cnt <= CNT_W'(aw_q) - 1'b1;
              end else begin
                cnt <= cnt - 1'b1;
              end
            end
            SEG_ADR: begin
              if (size_q && !ee_do) begin
                found_aw <= AW_W'(width_at(MAX_AW, int'(cnt)));
                seg      <= SEG_DAT;
                cnt      <= CNT_W'(WORD_W - 1);
              end else if (cnt == '0) begin
                seg <= SEG_DAT;
                cnt <= CNT_W'(WORD_W - 1);
                if (size_q) begin
                  found_aw <= AW_W'(MAX_AW);
                  no_dummy <= 1'b1;
                end
              end else begin
                cnt <= cnt - 1'b1;
              end
            end
            default: begin
              word <= {word[WORD_W-2:0], ee_do};
              if (cnt == '0) st  <= SR_END;
              else           cnt <= cnt - 1'b1;
            end
          endcase
        end
        SR_END: if (tick) begin
          st         <= SR_IDLE;
          word_valid <= 1'b1;
        end
        default: st <= SR_IDLE;
      endcase
    end
  end

  // run length of the current serial clock level, saturating at HALF
  logic [HW-1:0] sk_run;
  logic          sk_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sk_q   <= 1'b0;
      sk_run <= HW'(HALF);
    end else begin
      sk_q <= ee_sk;
      if (ee_sk != sk_q)            sk_run <= HW'(1);
      else if (sk_run != HW'(HALF)) sk_run <= sk_run + 1'b1;
    end
  end

  AST_SK_HALF_MIN: assert property (@(posedge clk) disable iff (!rst_n)
    (ee_sk != sk_q) |-> (sk_run >= HW'(HALF))); // R3
  AST_LINES_LOW_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid |-> (!ee_cs && !ee_sk && !ee_di)); // R7
  AST_GO_ONLY_WHEN_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (go && ready) |=> ee_cs); // R2
endmodule

// File: rtl/mwr_store.sv
module mwr_store
  import mwr_pkg::*;
#(
  parameter int unsigned MAX_AW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              we,
  input  logic [MAX_AW-1:0] waddr,
  input  logic [WORD_W-1:0] wdata,
  input  logic [MAX_AW-1:0] raddr,
  output logic [WORD_W-1:0] rdata,
  output logic [WORD_W-1:0] sum
);
  localparam int unsigned DEPTH = 1 << MAX_AW;

  logic [WORD_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata <= '0;
    else        rdata <= mem[raddr];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   sum <= '0;
    else if (clr) sum <= '0;
    else if (we)  sum <= sum_step(sum, wdata);
  end
endmodule

// File: rtl/mw_eeprom_loader.sv
module mw_eeprom_loader
  import mwr_pkg::*;
#(
  parameter int unsigned MAX_AW      = 8,
  parameter int unsigned CLK_MHZ     = 125,
  parameter int unsigned HALF_CYCLES = 125,
  parameter logic [15:0] CSUM_TARGET = 16'hBABA
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         start,
  output logic                         busy,
  output logic                         done,
  output logic                         csum_ok,
  output logic                         size_err,
  output logic [$clog2(MAX_AW+1)-1:0]  addr_width,
  input  logic [MAX_AW-1:0]            rd_addr,
  output logic [15:0]                  rd_data,
  output logic                         ee_cs,
  output logic                         ee_sk,
  output logic                         ee_di,
  input  logic                         ee_do
);
  localparam int unsigned AW_W     = $clog2(MAX_AW + 1);
  localparam int unsigned HALF_EFF = half_floor(HALF_CYCLES, CLK_MHZ);

  top_st_e           st;
  logic              pend;
  logic [MAX_AW-1:0] widx;
  logic [MAX_AW-1:0] last_idx;

  logic              tick;
  logic              ser_go;
  logic              ser_ready;
  logic              ser_active;
  logic              ser_valid;
  logic [WORD_W-1:0] ser_word;
  logic [AW_W-1:0]   ser_found;
  logic              ser_nodummy;
  logic [WORD_W-1:0] img_sum;
  logic              img_we;
  logic              img_clr;

  assign busy    = (st != TS_IDLE);
  assign ser_go  = ((st == TS_SIZE) || (st == TS_READ)) && ser_ready && !pend;
  assign img_we  = (st == TS_READ) && ser_valid;
  assign img_clr = (st == TS_IDLE) && start;

  mwr_tick #(.HALF(HALF_EFF)) u_tick (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (ser_active),
    .tick  (tick)
  );

  mwr_serial #(.MAX_AW(MAX_AW), .HALF(HALF_EFF)) u_serial (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (tick),
    .go         (ser_go),
    .sizing     (st == TS_SIZE),
    .aw         (addr_width),
    .addr       (widx),
    .ee_do      (ee_do),
    .ee_cs      (ee_cs),
    .ee_sk      (ee_sk),
    .ee_di      (ee_di),
    .ready      (ser_ready),
    .active     (ser_active),
    .word_valid (ser_valid),
    .word       (ser_word),
    .found_aw   (ser_found),
    .no_dummy   (ser_nodummy)
  );

  mwr_store #(.MAX_AW(MAX_AW)) u_store (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (img_clr),
    .we    (img_we),
    .waddr (widx),
    .wdata (ser_word),
    .raddr (rd_addr),
    .rdata (rd_data),
    .sum   (img_sum)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= TS_IDLE;
      pend       <= 1'b0;
      widx       <= '0;
      last_idx   <= '0;
      done       <= 1'b0;
      csum_ok    <= 1'b0;
      size_err   <= 1'b0;
      addr_width <= '0;
    end else begin
      done <= 1'b0;
      if (ser_go)         pend <= 1'b1;
      else if (ser_valid) pend <= 1'b0;
      case (st)
        TS_IDLE: if (start) begin
          st       <= TS_SIZE;
          csum_ok  <= 1'b0;
          size_err <= 1'b0;
          widx     <= '0;
        end
        TS_SIZE: if (ser_valid) begin
          addr_width <= ser_found;
          size_err   <= ser_nodummy;
          last_idx   <= MAX_AW'(last_word(int'(ser_found)));
          widx       <= '0;
          st         <= TS_READ;
        end
        TS_READ: if (ser_valid) begin
          if (widx == last_idx) st   <= TS_FIN;
          else                  widx <= widx + 1'b1;
        end
        default: begin
          st      <= TS_IDLE;
          done    <= 1'b1;
          csum_ok <= (img_sum == CSUM_TARGET);
        end
      endcase
    end
  end

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R9
  AST_ERR_FULL_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    size_err |-> (addr_width == AW_W'(MAX_AW))); // R5
  AST_WIDTH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    ((st == TS_READ) && $past(st == TS_READ)) |-> $stable(addr_width)); // R10
  AST_CS_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    ee_cs |-> busy); // R2
  AST_IDX_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (st == TS_READ) |-> (widx <= last_idx)); // R11
endmodule

// File: tb/mw_eeprom_loader_tb.sv
module mw_eeprom_loader_tb;
  localparam int unsigned MAX_AW = 8;
  localparam int unsigned HALF_EFF = 2;
  localparam int NCASE = 6;
  // stimulus: device width, no-dummy device, checksum fixed up, data seed
  localparam int C_W    [NCASE] = '{6, 6, 8, 1, 4, 8};
  localparam int C_ND   [NCASE] = '{0, 0, 0, 0, 0, 1};
  localparam int C_GOOD [NCASE] = '{1, 0, 1, 1, 0, 0};
  localparam int C_SEED [NCASE] = '{3, 5, 7, 9, 11, 13};
  // expected: width, size error, checksum ok
  localparam int E_W    [NCASE] = '{6, 6, 8, 1, 4, 8};
  localparam int E_ERR  [NCASE] = '{0, 0, 0, 0, 0, 1};
  localparam int E_OK   [NCASE] = '{1, 0, 1, 1, 0, 0};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [MAX_AW-1:0] rd_addr = '0;
  logic ee_do = 1'b1;
  logic busy, done, csum_ok, size_err, ee_cs, ee_sk, ee_di;
  logic [3:0] addr_width;
  logic [15:0] rd_data;

  always #4 clk = ~clk;

  mw_eeprom_loader #(.MAX_AW(MAX_AW), .CLK_MHZ(2), .HALF_CYCLES(1)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
    .csum_ok(csum_ok), .size_err(size_err), .addr_width(addr_width),
    .rd_addr(rd_addr), .rd_data(rd_data),
    .ee_cs(ee_cs), .ee_sk(ee_sk), .ee_di(ee_di), .ee_do(ee_do));

  int checks = 0;
  int fails = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // behavioural three-wire EEPROM
  logic [15:0] mem [256];
  int model_w = 6;
  bit model_nd = 1'b0;
  int bitn = 0;
  int cmd_bad = 0;
  int cs_windows = 0;
  logic [7:0] maddr = '0;

  initial begin
    forever begin
      @(posedge ee_sk or negedge ee_cs);
      if (!ee_cs) begin
        bitn = 0; ee_do = 1'b1; maddr = '0;
      end else begin
        if (bitn < 3) begin
          if (ee_di !== ((bitn == 2) ? 1'b0 : 1'b1)) cmd_bad++;
        end else if (bitn < 3 + model_w) begin
          maddr = {maddr[6:0], ee_di};
          if (bitn == 2 + model_w && !model_nd) ee_do = 1'b0;
        end else if (bitn < 19 + model_w) begin
          ee_do = model_nd ? 1'b1 : mem[maddr][15 - (bitn - 3 - model_w)];
        end else begin
          ee_do = 1'b1;
        end
        bitn++;
      end
    end
  end

  initial forever begin
    @(posedge ee_cs);
    cs_windows++;
  end

  int done_cnt = 0;
  int sk_run = 0;
  int sk_min = 1000;
  always @(negedge clk) begin
    if (done) done_cnt++;
    if (ee_sk) sk_run++;
    else if (sk_run != 0) begin
      if (sk_run < sk_min) sk_min = sk_run;
      sk_run = 0;
    end
  end

  task automatic fill(input int c);
    logic [15:0] s;
    s = '0;
    for (int i = 0; i < 256; i++) begin
      mem[i] = 16'(C_SEED[c] * 16'h1F3D + i * 16'h0457) ^ 16'(i << 7);
    end
    for (int i = 0; i < (1 << C_W[c]) - 1; i++) s = s + mem[i];
    // last word fixes the sum to the target, or misses it by one
    mem[(1 << C_W[c]) - 1] = 16'hBABA - s + (C_GOOD[c] ? 16'h0 : 16'h1);
  endtask

  task automatic run_case(input int c);
    int w0, d0, n, t;
    logic [15:0] expw;
    model_w = C_W[c];
    model_nd = C_ND[c];
    fill(c);
    w0 = cs_windows;
    d0 = done_cnt;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk("R9 busy after start", busy, 1);
    repeat (30) @(negedge clk);
    start = 1'b1;                      // R10: ignored while busy
    @(negedge clk); start = 1'b0;
    t = 0;
    while (!done && t < 60000) begin @(negedge clk); t++; end
    chk("R9 done seen", done, 1);
    chk("R9 busy low with done", busy, 0);
    chk("R4 width", addr_width, E_W[c]);
    chk("R5 size error", size_err, E_ERR[c]);
    chk("R8 checksum", csum_ok, E_OK[c]);
    n = 1 << E_W[c];
    for (int i = 0; i < n; i++) begin
      rd_addr = MAX_AW'(i);
      @(negedge clk);
      expw = model_nd ? 16'hFFFF : mem[i];
      chk("R6 R11 word", rd_data, expw);
    end
    repeat (4) @(negedge clk);
    chk("R7 chip-select windows", cs_windows - w0, 1 + n);
    chk("R10 single done", done_cnt - d0, 1);
    chk("R2 command bits", cmd_bad, 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 cs", ee_cs, 0);
    chk("R1 sk", ee_sk, 0);
    chk("R1 di", ee_di, 0);
    chk("R1 busy", busy, 0);
    chk("R1 done", done, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 idle after release", {busy, ee_cs}, 0);
    for (int c = 0; c < NCASE; c++) run_case(c);
    // R3 serial clock level length equals the floored half period
    chk("R3 sk half period", sk_min, HALF_EFF);
    // lines idle after last run
    chk("R7 lines low idle", {ee_cs, ee_sk, ee_di}, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule